// File: doc/BRIEF.md
# Address-Range Cache Operation Sequencer

This block carries out one ranged memory-subsystem instruction. Its inputs are a decoded minor function (funct3), a 7-bit operation selector (funct7), a region base address, an inclusive upper-bound address, and a flag that is set when the destination register is x0. It breaks the region into cache lines. Starting from the base rounded down to a line boundary, it issues one request per line on a valid/ready command port, in ascending order, until it reaches the line that holds the bound. Each request asks the cache for an operation: a data fence, an invalidate, a discard (drop the line without writeback) or a prefetch.

When the walk ends, the block returns a result address on a completion handshake. The result is the first address past the last line that completed, taken in contiguous order. Software can therefore restart the instruction from that address after a partial completion. Non-fence operations can end early in two ways: when the cache reports a failed line, or when an abort request (such as a pending interrupt) arrives at a line's acknowledgement. If the destination is x0 and the operation is not a fence, the block signals completion at once and keeps walking in the background. Fences always run over the whole region and always complete synchronously.

Top module: `rangeOpSeq`

## Requirements
- R1: An instruction is legal only when funct3 is 3'b001 and funct7 is one of 0 (instruction fence), 2 (ranged data fence), 3 (invalidate), 4 (discard) or 5 (prefetch). Any other value, including the reserved funct7 1, completes with doneIllegal=1 and doneAddr equal to the base address, and issues no command.
- R2: A legal ranged operation issues one command per line. The commands start at the base rounded down to LINE_BYTES and end at the bound rounded down, in ascending order. cmdOp is 1 for the data fence, 2 for invalidate, 3 for discard and 4 for prefetch. cmdValid, cmdOp and cmdAddr hold steady until cmdReady is seen.
- R3: When the walk completes, the result is the last line address plus LINE_BYTES, modulo 2^AW. A region that reaches the top of the address space therefore returns 0.
- R4: If the bound is below the base, the region is empty. A non-instruction-fence operation on an empty region issues no command and returns the base address.
- R5: If cmdErr is high at a non-fence acknowledgement, the walk stops. The result is that line's address, or the base address if the failing line is the first line.
- R6: If abortReq is high at a non-fence acknowledgement, that line counts as done and the walk stops. The result is that line's address plus LINE_BYTES.
- R7: Fences ignore abortReq. A line acknowledged with cmdErr is issued again. Fences complete synchronously even when rdIsZero=1.
- R8: A non-fence operation with rdIsZero=1 raises doneValid one cycle after it is accepted, with doneAddr equal to the base address, and the walk continues after that. instReady stays low until the walk has ended and the completion has been taken.
- R9: The instruction fence ignores the base and bound. It issues exactly one command, with cmdOp 0 and address 0, and returns 0.
- R10: After reset the block is idle, with instReady=1, cmdValid=0 and doneValid=0. doneValid, doneAddr and doneIllegal hold steady until doneReady is seen.
- R11: A synchronous operation raises doneValid in the cycle after its last command acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Block idle; the instruction is taken on this edge |
| funct3 | input | 3 | Minor function code |
| funct7 | input | 7 | Operation selector |
| baseAddr | input | AW | Region base address |
| boundAddr | input | AW | Region inclusive upper bound |
| rdIsZero | input | 1 | Destination register is x0 |
| abortReq | input | 1 | Stop a non-fence walk at this acknowledgement |
| cmdValid | output | 1 | Cache command valid |
| cmdReady | input | 1 | Cache accepts the command |
| cmdErr | input | 1 | Line failed; sampled with cmdReady |
| cmdOp | output | 3 | Command code |
| cmdAddr | output | AW | Line-aligned command address |
| doneValid | output | 1 | Completion valid |
| doneReady | input | 1 | Completion taken |
| doneAddr | output | AW | Result address |
| doneIllegal | output | 1 | Instruction was illegal |

## Verification
Every result has a due cycle. Immediate completions (illegal, empty region and background-retired operations) must appear on the edge that accepts the instruction, one cycle after the bench drives it. Synchronous completions must appear on the edge right after the last command acknowledgement. The bench records the accept edge and each acknowledgement edge and compares these with the first cycle in which doneValid is seen. Expected commands and results go into scoreboard queues. The bench pops the command queue only when a handshake is certain at the next edge, and it holds doneReady low for a few cycles to check that the completion stays stable.

// File: rtl/rangeop_pkg.sv
package rangeop_pkg;

  localparam logic [2:0] F3_REGION = 3'b001;

  localparam logic [6:0] F7_IFENCE   = 7'd0;
  localparam logic [6:0] F7_DFENCE   = 7'd2;
  localparam logic [6:0] F7_INVAL    = 7'd3;
  localparam logic [6:0] F7_DISCARD  = 7'd4;
  localparam logic [6:0] F7_PREFETCH = 7'd5;

  typedef enum logic [2:0] {
    OP_IFENCE   = 3'd0,
    OP_DFENCE   = 3'd1,
    OP_INVAL    = 3'd2,
    OP_DISCARD  = 3'd3,
    OP_PREFETCH = 3'd4
  } cmdOpE;

  typedef enum logic [1:0] {
    RES_BASE = 2'd0,
    RES_NEXT = 2'd1,
    RES_CUR  = 2'd2,
    RES_ZERO = 2'd3
  } resSelE;

  typedef struct packed {
    logic   load;
    logic   zeroRange;
    logic   advance;
    logic   resLoad;
    resSelE resSel;
  } seqStrobeT;

endpackage

// File: rtl/rangeOpDatapath.sv
module rangeOpDatapath
  import rangeop_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobeT     stb,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] boundAddr,
  output logic          rangeEmpty,
  output logic          isLast,
  output logic [AW-1:0] lineAddr,
  output logic [AW-1:0] resAddr
);

  localparam logic [AW-1:0] LINE_STEP = AW'(LINE_BYTES);
  localparam logic [AW-1:0] LINE_MASK = ~(LINE_STEP - 1'b1);

  logic [AW-1:0] baseQ;
  logic [AW-1:0] curLineQ;
  logic [AW-1:0] lastLineQ;
  logic [AW-1:0] resQ;
  logic [AW-1:0] nextLine;
  logic [AW-1:0] curResult;
  logic          atFirst;

  assign rangeEmpty = boundAddr < baseAddr;
  assign nextLine   = curLineQ + LINE_STEP;
  assign atFirst    = curLineQ == (baseQ & LINE_MASK);
  assign curResult  = atFirst ? baseQ : curLineQ;
  assign isLast     = curLineQ == lastLineQ;
  assign lineAddr   = curLineQ;
  assign resAddr    = resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      curLineQ  <= '0;
      lastLineQ <= '0;
    end else if (stb.load) begin
      baseQ     <= baseAddr;
      curLineQ  <= stb.zeroRange ? '0 : (baseAddr & LINE_MASK);
      lastLineQ <= stb.zeroRange ? '0 : (boundAddr & LINE_MASK);
    end else if (stb.advance) begin
      curLineQ  <= nextLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= '0;
    end else if (stb.resLoad) begin
      unique case (stb.resSel)
        RES_BASE: resQ <= baseAddr;
        RES_NEXT: resQ <= nextLine;
        RES_CUR:  resQ <= curResult;
        default:  resQ <= '0;
      endcase
    end
  end

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (curLineQ - $past(curLineQ)) == LINE_STEP);

endmodule

// File: rtl/rangeOpCtrl.sv
module rangeOpCtrl
  import rangeop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  output logic       instReady,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  input  logic       rdIsZero,
  input  logic       abortReq,
  input  logic       rangeEmpty,
  input  logic       isLast,
  output logic       cmdValid,
  input  logic       cmdReady,
  input  logic       cmdErr,
  output logic [2:0] cmdOp,
  output logic       doneValid,
  input  logic       doneReady,
  output logic       doneIllegal,
  output seqStrobeT  stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} stateE;

  stateE     state, nextState;
  cmdOpE     opQ, decOp;
  logic      fenceQ, asyncQ, doneValidQ, illegalQ;
  logic      decLegal, decFence, decAsync, doneSet, accept, handshake;

  always_comb begin
    decLegal = funct3 == F3_REGION;
    decOp    = OP_INVAL;
    unique case (funct7)
      F7_IFENCE:   decOp = OP_IFENCE;
      F7_DFENCE:   decOp = OP_DFENCE;
      F7_INVAL:    decOp = OP_INVAL;
      F7_DISCARD:  decOp = OP_DISCARD;
      F7_PREFETCH: decOp = OP_PREFETCH;
      default:     decLegal = 1'b0;
    endcase
    decFence = (decOp == OP_IFENCE) || (decOp == OP_DFENCE);
    decAsync = rdIsZero && !decFence;
  end

  assign accept    = (state == ST_IDLE) && instValid;
  assign handshake = (state == ST_WALK) && cmdReady;

  always_comb begin
    stb       = '{load: 1'b0, zeroRange: 1'b0, advance: 1'b0,
                  resLoad: 1'b0, resSel: RES_BASE};
    nextState = state;
    doneSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (instValid) begin
          stb.load      = 1'b1;
          stb.zeroRange = decOp == OP_IFENCE;
          if (!decLegal || (decOp != OP_IFENCE && rangeEmpty)) begin
            doneSet     = 1'b1;
            stb.resLoad = 1'b1;
            stb.resSel  = RES_BASE;
            nextState   = ST_DONE;
          end else begin
            nextState = ST_WALK;
            if (decAsync) begin
              doneSet     = 1'b1;
              stb.resLoad = 1'b1;
              stb.resSel  = RES_BASE;
            end
          end
        end
      end
      ST_WALK: begin
        if (cmdReady) begin
          if (fenceQ) begin
            if (!cmdErr) begin
              if (isLast) begin
                nextState   = ST_DONE;
                doneSet     = 1'b1;
                stb.resLoad = 1'b1;
                stb.resSel  = (opQ == OP_IFENCE) ? RES_ZERO : RES_NEXT;
              end else begin
                stb.advance = 1'b1;
              end
            end
          end else if (cmdErr || isLast || abortReq) begin
            nextState   = ST_DONE;
            doneSet     = !asyncQ;
            stb.resLoad = !asyncQ;
            stb.resSel  = cmdErr ? RES_CUR : RES_NEXT;
          end else begin
            stb.advance = 1'b1;
          end
        end
      end
      default: begin
        if (!doneValidQ || doneReady) nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      opQ        <= OP_IFENCE;
      fenceQ     <= 1'b0;
      asyncQ     <= 1'b0;
      illegalQ   <= 1'b0;
      doneValidQ <= 1'b0;
    end else begin
      state      <= nextState;
      doneValidQ <= doneSet || (doneValidQ && !doneReady);
      if (accept) begin
        opQ      <= decOp;
        fenceQ   <= decFence;
        asyncQ   <= decAsync;
        illegalQ <= !decLegal;
      end
    end
  end

  assign instReady   = state == ST_IDLE;
  assign cmdValid    = state == ST_WALK;
  assign cmdOp       = opQ;
  assign doneValid   = doneValidQ;
  assign doneIllegal = illegalQ;

  // R1
  illegal_nocmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneIllegal) |-> !cmdValid);

  // R7
  fence_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handshake && fenceQ && !isLast) |=> cmdValid);

  // R8
  async_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && decLegal && decAsync && !rangeEmpty) |=> (doneValid && cmdValid));

  // R11
  sync_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handshake && !asyncQ && isLast && !cmdErr) |=> doneValid);

endmodule

// File: rtl/rangeOpSeq.sv
module rangeOpSeq
  import rangeop_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  output logic          instReady,
  input  logic [2:0]    funct3,
  input  logic [6:0]    funct7,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] boundAddr,
  input  logic          rdIsZero,
  input  logic          abortReq,
  output logic          cmdValid,
  input  logic          cmdReady,
  input  logic          cmdErr,
  output logic [2:0]    cmdOp,
  output logic [AW-1:0] cmdAddr,
  output logic          doneValid,
  input  logic          doneReady,
  output logic [AW-1:0] doneAddr,
  output logic          doneIllegal
);

  seqStrobeT stb;
  logic      rangeEmpty;
  logic      isLast;

  rangeOpCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instReady  (instReady),
    .funct3     (funct3),
    .funct7     (funct7),
    .rdIsZero   (rdIsZero),
    .abortReq   (abortReq),
    .rangeEmpty (rangeEmpty),
    .isLast     (isLast),
    .cmdValid   (cmdValid),
    .cmdReady   (cmdReady),
    .cmdErr     (cmdErr),
    .cmdOp      (cmdOp),
    .doneValid  (doneValid),
    .doneReady  (doneReady),
    .doneIllegal(doneIllegal),
    .stb        (stb)
  );

  rangeOpDatapath #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .baseAddr   (baseAddr),
    .boundAddr  (boundAddr),
    .rangeEmpty (rangeEmpty),
    .isLast     (isLast),
    .lineAddr   (cmdAddr),
    .resAddr    (doneAddr)
  );

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdOp)));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneReady) |=>
      (doneValid && $stable(doneAddr) && $stable(doneIllegal)));

endmodule

// File: tb/sim_rangeOpSeq.sv
module sim_rangeOpSeq;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int LINE       = 64;
  localparam logic [AW-1:0] MASK = ~(AW'(LINE) - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic          instReady;
  logic [2:0]    funct3 = '0;
  logic [6:0]    funct7 = '0;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] boundAddr = '0;
  logic          rdIsZero = 1'b0;
  logic          abortReq = 1'b0;
  logic          cmdValid;
  logic          cmdReady = 1'b0;
  logic          cmdErr = 1'b0;
  logic [2:0]    cmdOp;
  logic [AW-1:0] cmdAddr;
  logic          doneValid;
  logic          doneReady = 1'b0;
  logic [AW-1:0] doneAddr;
  logic          doneIllegal;

  rangeOpSeq #(.AW(AW), .LINE_BYTES(LINE)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  logic [AW+2:0] cmdQ[$];   // {op[2:0], addr}
  logic [AW+1:0] doneQ[$];  // {illegal, dueAtAccept, addr}
  string curReq = "R2";
  int    errIdx = -1, abortIdx = -1, hsIdx = 0;
  bit    stallOn = 0, doneStallOn = 0;
  int    acceptCyc = 0, lastHsCyc = 0, doneWait = 0;
  bit    donePend = 0;
  logic [AW-1:0] heldAddr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // responder / monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        automatic bit rdy = stallOn ? ((cyc % 3) != 1) : 1'b1;
        cmdReady = rdy;
        cmdErr   = rdy && cmdValid && (hsIdx == errIdx);
        abortReq = rdy && cmdValid && (hsIdx == abortIdx);
        if (cmdValid && rdy) begin
          if (cmdQ.size() == 0) begin
            chk(0, curReq, "unexpected command", {29'd0, cmdOp, cmdAddr}, 64'd0);
          end else begin
            automatic logic [AW+2:0] e = cmdQ.pop_front();
            chk({cmdOp, cmdAddr} == e, curReq, "command op/addr",
                {29'd0, cmdOp, cmdAddr}, {29'd0, e});
          end
          hsIdx++;
          lastHsCyc = cyc + 1;
        end
        if (doneValid) begin
          if (!donePend) begin
            if (doneQ.size() != 0) begin
              automatic int due = doneQ[0][AW] ? acceptCyc : lastHsCyc;
              chk(cyc == due, doneQ[0][AW] ? "R8" : "R11", "done cycle", cyc, due);
            end
            heldAddr = doneAddr;
          end else begin
            chk(doneAddr == heldAddr, "R10", "done held stable", doneAddr, heldAddr);
          end
          if (!doneStallOn || doneWait >= 2) begin
            doneReady = 1'b1;
            donePend  = 0;
            doneWait  = 0;
            if (doneQ.size() == 0) begin
              chk(0, curReq, "unexpected completion", doneAddr, 0);
            end else begin
              automatic logic [AW+1:0] d = doneQ.pop_front();
              chk(doneAddr == d[AW-1:0], curReq, "result address", doneAddr, d[AW-1:0]);
              chk(doneIllegal == d[AW+1], "R1", "illegal flag", doneIllegal, d[AW+1]);
            end
          end else begin
            doneReady = 1'b0;
            donePend  = 1;
            doneWait++;
          end
        end else begin
          doneReady = 1'b0;
          donePend  = 0;
        end
      end
    end
  end

  function automatic int opOf(input logic [6:0] f7);
    case (f7)
      7'd0: return 0;
      7'd2: return 1;
      7'd3: return 2;
      7'd4: return 3;
      7'd5: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic runOp(input string req, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [AW-1:0] b, input logic [AW-1:0] bd, input bit rdz,
                       input int eAt, input int aAt, input bit stall, input bit dstall);
    int op;
    bit fence, async, legal;
    logic [AW-1:0] res;
    op    = opOf(f7);
    legal = (f3 == 3'b001) && (op >= 0);
    fence = (op == 0) || (op == 1);
    async = rdz && !fence;
    curReq = req; errIdx = eAt; abortIdx = aAt; hsIdx = 0;
    stallOn = stall; doneStallOn = dstall;
    if (!legal) begin
      doneQ.push_back({1'b1, 1'b1, b});
    end else if (op == 0) begin
      for (int i = 0; i <= ((eAt == 0) ? 1 : 0); i++) cmdQ.push_back({3'd0, {AW{1'b0}}});
      doneQ.push_back({1'b0, 1'b0, {AW{1'b0}}});
    end else if (bd < b) begin
      doneQ.push_back({1'b0, 1'b1, b});
    end else begin
      automatic logic [AW-1:0] ln = b & MASK;
      automatic int idx = 0;
      forever begin
        cmdQ.push_back({3'(op), ln});
        if (idx == eAt) begin
          idx++;
          if (fence) continue;
          res = (ln == (b & MASK)) ? b : ln;
          break;
        end
        if (ln == (bd & MASK) || (!fence && idx == aAt)) begin
          res = ln + AW'(LINE);
          break;
        end
        idx++;
        ln = ln + AW'(LINE);
      end
      doneQ.push_back({1'b0, async, async ? b : res});
    end
    // drive the instruction
    @(negedge clk);
    while (!instReady) @(negedge clk);
    funct3 = f3; funct7 = f7; baseAddr = b; boundAddr = bd; rdIsZero = rdz;
    instValid = 1'b1;
    acceptCyc = cyc + 1;
    @(negedge clk);
    instValid = 1'b0;
    baseAddr = ~b; boundAddr = ~bd;   // operands change after accept
    while (cmdQ.size() != 0 || doneQ.size() != 0 || !instReady) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!cmdValid && !doneValid, req, "idle after op", {cmdValid, doneValid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(instReady == 1'b1, "R10", "reset instReady", instReady, 1);
    chk(cmdValid == 1'b0, "R10", "reset cmdValid", cmdValid, 0);
    chk(doneValid == 1'b0, "R10", "reset doneValid", doneValid, 0);
    rstN = 1'b1;
    // R2 R3: invalidate, unaligned base, four lines
    runOp("R2", 3'b001, 7'd3, 32'h1010, 32'h10C5, 0, -1, -1, 0, 0);
    // R2: discard single line under command stalls
    runOp("R2", 3'b001, 7'd4, 32'h2000, 32'h2000, 0, -1, -1, 1, 0);
    // R6: prefetch aborted at second acknowledgement
    runOp("R6", 3'b001, 7'd5, 32'h3000, 32'h33FF, 0, -1, 1, 0, 0);
    // R5: first line fails -> base returned
    runOp("R5", 3'b001, 7'd3, 32'h4010, 32'h41FF, 0, 0, -1, 0, 0);
    // R5: third line fails -> address of failing line
    runOp("R5", 3'b001, 7'd3, 32'h4010, 32'h41FF, 0, 2, -1, 1, 0);
    // R7: data fence ignores abort, reissues failed line, sync despite rd=x0
    runOp("R7", 3'b001, 7'd2, 32'h5000, 32'h50BF, 1, 1, 0, 0, 0);
    // R8 R10: background discard with completion held off
    runOp("R8", 3'b001, 7'd4, 32'h6004, 32'h60FF, 1, -1, -1, 1, 1);
    // R3: wraps past the top of the address space
    runOp("R3", 3'b001, 7'd5, 32'hFFFFFF90, 32'hFFFFFFFF, 0, -1, -1, 0, 0);
    // R4: empty region
    runOp("R4", 3'b001, 7'd3, 32'h7000, 32'h6FFF, 0, -1, -1, 0, 0);
    // R1: reserved, unknown funct7, wrong funct3
    runOp("R1", 3'b001, 7'd1, 32'h8000, 32'h80FF, 0, -1, -1, 0, 0);
    runOp("R1", 3'b001, 7'h40, 32'h8040, 32'h80FF, 0, -1, -1, 0, 1);
    runOp("R1", 3'b000, 7'd3, 32'h8080, 32'h80FF, 0, -1, -1, 0, 0);
    // R9: instruction fence ignores operands
    runOp("R9", 3'b001, 7'd0, 32'h1234, 32'h5678, 0, -1, -1, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R10", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule